// File: doc/BRIEF.md
# Dual-Layer VGA Scan Compositor

This block produces the raster scan for a parallel VGA-style display and merges two pixel layers into the color that goes out. Free-running horizontal and vertical counters issue the coordinate of the next pixel to fetch, together with a flag that says whether that coordinate lies in the visible picture. The surrounding memory system returns, one display clock later, the foreground color, the background color and a per-pixel layer enable bit for that coordinate. The block then drives the color it selected, or black during blanking.

The selection rule is simple. The foreground wins when its stored enable bit is set and a global foreground-show control was high when the coordinate was issued. In every other case the background is shown. The sync outputs are active low and are delayed by one stage so that they line up with the color. The blank output is active low and derived only from the two syncs. The default timing is 640x480 at 60 Hz: 800 clocks per line and 525 lines per frame, with 10-bit color channels.

Top module: `vga_layer_compositor`

## Requirements
- R1: pos_x counts up by one on every clock from 0 to H_TOTAL-1 and then wraps to 0. pos_y counts up by one when pos_x wraps, from 0 to V_TOTAL-1, and then wraps to 0. H_TOTAL = H_VIS+H_FP+H_SYNC+H_BP (default 640+16+96+48 = 800) and V_TOTAL = V_VIS+V_FP+V_SYNC+V_BP (default 480+10+2+33 = 525).
- R2: pos_valid is high exactly when pos_x < H_VIS and pos_y < V_VIS.
- R3: hsync_n is low in the cycle after pos_x was in the range H_VIS+H_FP to H_VIS+H_FP+H_SYNC-1, and high otherwise. With the defaults this gives 96 low clocks per 800-clock line.
- R4: vsync_n is low in the cycle after pos_y was in the range V_VIS+V_FP to V_VIS+V_FP+V_SYNC-1, and high otherwise.
- R5: blank_n is low whenever hsync_n or vsync_n is low, and high when both are high.
- R6: The color driven in cycle t+1 belongs to the coordinate issued in cycle t. It is formed from the fg_en, fg_* and bg_* values presented in cycle t+1, and fg_show is sampled in cycle t.
- R7: When fg_show was 1 and fg_en is 1, out_* equals fg_*, and bg_* has no effect.
- R8: When fg_en is 0, out_* equals bg_*.
- R9: When fg_show was 0, out_* equals bg_* whatever fg_en holds.
- R10: out_* is all zero in the cycle after a coordinate with pos_valid low was issued.
- R11: While rst is high (synchronous, active high), pos_x and pos_y are 0, hsync_n, vsync_n and blank_n are 1, and out_* is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fg_show | input | 1 | Global foreground-show control, sampled with the issued coordinate |
| fg_en | input | 1 | Per-pixel foreground enable bit, one clock after the coordinate |
| fg_r | input | 10 | Foreground red, one clock after the coordinate |
| fg_g | input | 10 | Foreground green |
| fg_b | input | 10 | Foreground blue |
| bg_r | input | 10 | Background red, one clock after the coordinate |
| bg_g | input | 10 | Background green |
| bg_b | input | 10 | Background blue |
| pos_x | output | X_W (10 by default) | Column of the next pixel to fetch |
| pos_y | output | Y_W (10 by default) | Row of the next pixel to fetch |
| pos_valid | output | 1 | Issued coordinate lies in the visible area |
| hsync_n | output | 1 | Horizontal sync, active low, aligned with the color |
| vsync_n | output | 1 | Vertical sync, active low, aligned with the color |
| blank_n | output | 1 | Blank, active low, low while either sync is low |
| out_r | output | 10 | Displayed red |
| out_g | output | 10 | Displayed green |
| out_b | output | 10 | Displayed blue |

## Verification
Two things can happen in the same cycle: the registered foreground-show control changes, and a new per-pixel enable bit and new colors arrive for a visible coordinate. The bench changes fg_show in the cycle a visible coordinate is issued and changes the enable bit and both colors in the next cycle. It then judges that the selected color follows the show value sampled with the coordinate, not the value current when the color is driven. A second collision happens at the last visible column, where the edge of the visible area meets the one-cycle delay of syncs and color. A per-cycle sweep over two frames of a reduced timing compares positions, syncs, blank and the forced-black color against a model that counts clocks. A separate instance with the default horizontal timing checks the 800-clock line, its 640 visible columns and its 96 sync clocks.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

    localparam int COLOR_W = 10;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
    } rgb_t;

    typedef enum logic {
        LAYER_BG = 1'b0,
        LAYER_FG = 1'b1
    } layer_e;

    localparam rgb_t RGB_BLACK = '{r: '0, g: '0, b: '0};

    // Counter width needed to hold 0 .. total-1
    function automatic int span_width(int total);
        return (total <= 2) ? 1 : $clog2(total);
    endfunction

    function automatic layer_e pick_layer(logic show, logic en);
        return (show && en) ? LAYER_FG : LAYER_BG;
    endfunction

endpackage

// File: rtl/vlc_scan_axis.sv
module vlc_scan_axis #(
    parameter int VIS  = 640,
    parameter int FP   = 16,
    parameter int SYNC = 96,
    parameter int BP   = 48,
    localparam int TOTAL = VIS + FP + SYNC + BP,
    localparam int CW    = vlc_pkg::span_width(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          last,
    output logic          active,
    output logic          in_sync
);

    localparam logic [CW-1:0] LAST_C    = CW'(TOTAL - 1);
    localparam logic [CW-1:0] VIS_C     = CW'(VIS);
    localparam logic [CW-1:0] SYNC_LO_C = CW'(VIS + FP);
    localparam logic [CW-1:0] SYNC_HI_C = CW'(VIS + FP + SYNC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (step) begin
            count <= last ? '0 : count + CW'(1);
        end
    end

    always_comb begin
        last    = (count == LAST_C);
        active  = (count < VIS_C);
        in_sync = (count >= SYNC_LO_C) && (count <= SYNC_HI_C);
    end

    // R1
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |=> (count == $past(count) + CW'(1)));

    // R1
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (step && last) |=> (count == '0));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(count));

endmodule

// File: rtl/vlc_layer_mux.sv
module vlc_layer_mux
    import vlc_pkg::*;
(
    input  logic vis,
    input  logic show,
    input  logic en,
    input  rgb_t fg,
    input  rgb_t bg,
    output rgb_t pix
);

    always_comb begin
        pix = RGB_BLACK;
        if (vis) begin
            case (pick_layer(show, en))
                LAYER_FG: pix = fg;
                default:  pix = bg;
            endcase
        end
    end

endmodule

// File: rtl/vga_layer_compositor.sv
module vga_layer_compositor #(
    parameter int H_VIS  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_VIS  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    localparam int X_W = vlc_pkg::span_width(H_VIS + H_FP + H_SYNC + H_BP),
    localparam int Y_W = vlc_pkg::span_width(V_VIS + V_FP + V_SYNC + V_BP)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fg_show,
    input  logic                       fg_en,
    input  logic [vlc_pkg::COLOR_W-1:0] fg_r,
    input  logic [vlc_pkg::COLOR_W-1:0] fg_g,
    input  logic [vlc_pkg::COLOR_W-1:0] fg_b,
    input  logic [vlc_pkg::COLOR_W-1:0] bg_r,
    input  logic [vlc_pkg::COLOR_W-1:0] bg_g,
    input  logic [vlc_pkg::COLOR_W-1:0] bg_b,
    output logic [X_W-1:0]             pos_x,
    output logic [Y_W-1:0]             pos_y,
    output logic                       pos_valid,
    output logic                       hsync_n,
    output logic                       vsync_n,
    output logic                       blank_n,
    output logic [vlc_pkg::COLOR_W-1:0] out_r,
    output logic [vlc_pkg::COLOR_W-1:0] out_g,
    output logic [vlc_pkg::COLOR_W-1:0] out_b
);
    import vlc_pkg::*;

    localparam logic [X_W-1:0] H_VIS_C = X_W'(H_VIS);
    localparam logic [Y_W-1:0] V_VIS_C = Y_W'(V_VIS);

    logic h_last, h_act, h_sync;
    logic v_last, v_act, v_sync;
    logic vis_q, show_q;
    rgb_t fg_pix, bg_pix, shown;

    vlc_scan_axis #(
        .VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)
    ) u_h_axis (
        .clk     (clk),
        .rst     (rst),
        .step    (1'b1),
        .count   (pos_x),
        .last    (h_last),
        .active  (h_act),
        .in_sync (h_sync)
    );

    vlc_scan_axis #(
        .VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)
    ) u_v_axis (
        .clk     (clk),
        .rst     (rst),
        .step    (h_last),
        .count   (pos_y),
        .last    (v_last),
        .active  (v_act),
        .in_sync (v_sync)
    );

    assign pos_valid = h_act && v_act;

    // One stage of delay so syncs, blank and color describe the same pixel
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            vis_q   <= 1'b0;
            show_q  <= 1'b0;
        end else begin
            hsync_n <= ~h_sync;
            vsync_n <= ~v_sync;
            vis_q   <= pos_valid;
            show_q  <= fg_show;
        end
    end

    assign blank_n = hsync_n & vsync_n;

    assign fg_pix = '{r: fg_r, g: fg_g, b: fg_b};
    assign bg_pix = '{r: bg_r, g: bg_g, b: bg_b};

    vlc_layer_mux u_mux (
        .vis  (vis_q),
        .show (show_q),
        .en   (fg_en),
        .fg   (fg_pix),
        .bg   (bg_pix),
        .pix  (shown)
    );

    assign out_r = shown.r;
    assign out_g = shown.g;
    assign out_b = shown.b;

    // R1
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_last && v_last) |=> (pos_x == '0 && pos_y == '0));

    // R2
    valid_inside_chk: assert property (@(posedge clk) disable iff (rst)
        pos_valid |-> (pos_x < H_VIS_C && pos_y < V_VIS_C));

    // R3
    hsync_low_chk: assert property (@(posedge clk) disable iff (rst)
        h_sync |=> !hsync_n);

    // R4
    vsync_low_chk: assert property (@(posedge clk) disable iff (rst)
        v_sync |=> !vsync_n);

    // R5
    blank_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n || !vsync_n) |-> !blank_n);

    // R5
    blank_off_chk: assert property (@(posedge clk) disable iff (rst)
        (hsync_n && vsync_n) |-> blank_n);

    // R9
    bg_when_hidden_chk: assert property (@(posedge clk) disable iff (rst)
        (!fg_show && pos_valid) |=> (out_r == bg_r && out_g == bg_g && out_b == bg_b));

    // R10
    dark_outside_chk: assert property (@(posedge clk) disable iff (rst)
        !pos_valid |=> (out_r == '0 && out_g == '0 && out_b == '0));

endmodule

// File: tb/vga_layer_compositor_bench.sv
module vga_layer_compositor_bench;
    import vlc_pkg::*;

    localparam int CW   = COLOR_W;
    localparam int HT   = 15;   // 8 + 2 + 3 + 2
    localparam int VT   = 8;    // 4 + 1 + 2 + 1
    localparam int W_HT = 800;

    typedef struct packed {
        logic          show;
        logic          en;
        logic [CW-1:0] fgv;
        logic [CW-1:0] bgv;
        logic          sel_fg;
    } vec_t;

    // R7 R8 R9: {show, en, fg red, bg red, foreground expected}
    localparam vec_t VECS [8] = '{
        '{1'b1, 1'b1, 10'd100,  10'd200,  1'b1},
        '{1'b1, 1'b0, 10'd100,  10'd200,  1'b0},
        '{1'b0, 1'b1, 10'd300,  10'd400,  1'b0},
        '{1'b0, 1'b0, 10'd5,    10'd6,    1'b0},
        '{1'b1, 1'b1, 10'd1023, 10'd0,    1'b1},
        '{1'b1, 1'b0, 10'd0,    10'd1023, 1'b0},
        '{1'b0, 1'b1, 10'd512,  10'd1,    1'b0},
        '{1'b1, 1'b1, 10'd7,    10'd9,    1'b1}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst, fg_show, fg_en;
    logic [CW-1:0] fg_r, fg_g, fg_b, bg_r, bg_g, bg_b;

    logic [3:0] pos_x;
    logic [2:0] pos_y;
    logic pos_valid, hsync_n, vsync_n, blank_n;
    logic [CW-1:0] out_r, out_g, out_b;

    logic [9:0] w_pos_x;
    logic [2:0] w_pos_y;
    logic w_pos_valid, w_hsync_n, w_vsync_n, w_blank_n;
    logic [CW-1:0] w_out_r, w_out_g, w_out_b;

    vga_layer_compositor #(
        .H_VIS(8), .H_FP(2), .H_SYNC(3), .H_BP(2),
        .V_VIS(4), .V_FP(1), .V_SYNC(2), .V_BP(1)
    ) u_vga_layer_compositor (
        .clk(clk), .rst(rst), .fg_show(fg_show), .fg_en(fg_en),
        .fg_r(fg_r), .fg_g(fg_g), .fg_b(fg_b),
        .bg_r(bg_r), .bg_g(bg_g), .bg_b(bg_b),
        .pos_x(pos_x), .pos_y(pos_y), .pos_valid(pos_valid),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    vga_layer_compositor #(
        .V_VIS(2), .V_FP(1), .V_SYNC(1), .V_BP(1)
    ) u_vga_layer_compositor_wide (
        .clk(clk), .rst(rst), .fg_show(fg_show), .fg_en(fg_en),
        .fg_r(fg_r), .fg_g(fg_g), .fg_b(fg_b),
        .bg_r(bg_r), .bg_g(bg_g), .bg_b(bg_b),
        .pos_x(w_pos_x), .pos_y(w_pos_y), .pos_valid(w_pos_valid),
        .hsync_n(w_hsync_n), .vsync_n(w_vsync_n), .blank_n(w_blank_n),
        .out_r(w_out_r), .out_g(w_out_g), .out_b(w_out_b)
    );

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int w_valid_cnt = 0;
        int w_hs_low    = 0;
        int w_hs_first  = -1;

        rst = 1'b1;
        fg_show = 1'b1;
        fg_en   = 1'b1;
        fg_r = 10'd321; fg_g = 10'd654; fg_b = 10'd987;
        bg_r = 10'd11;  bg_g = 10'd22;  bg_b = 10'd33;
        repeat (3) @(posedge clk);
        @(negedge clk);

        // R11: reset state
        check("R11", "pos_x", pos_x, 0);
        check("R11", "pos_y", pos_y, 0);
        check("R11", "hsync_n", hsync_n, 1);
        check("R11", "vsync_n", vsync_n, 1);
        check("R11", "blank_n", blank_n, 1);
        check("R11", "out_r", out_r, 0);
        check("R11", "out_g", out_g, 0);
        check("R11", "out_b", out_b, 0);

        rst = 1'b0;
        if (w_pos_valid) w_valid_cnt++;

        // Per-cycle sweep: k posedges after reset release
        for (int k = 1; k <= W_HT; k++) begin
            int px, py, hx, vy;
            bit vis_prev;
            @(negedge clk);
            if (k <= 2 * HT * VT) begin
                px = k % HT;
                py = (k / HT) % VT;
                hx = (k - 1) % HT;
                vy = ((k - 1) / HT) % VT;
                vis_prev = (hx < 8) && (vy < 4);
                check("R1", "pos_x", pos_x, px);
                check("R1", "pos_y", pos_y, py);
                check("R2", "pos_valid", pos_valid, (px < 8 && py < 4) ? 1 : 0);
                check("R3", "hsync_n", hsync_n, (hx >= 10 && hx <= 12) ? 0 : 1);
                check("R4", "vsync_n", vsync_n, (vy >= 5 && vy <= 6) ? 0 : 1);
                check("R5", "blank_n", blank_n,
                      ((hx >= 10 && hx <= 12) || (vy >= 5 && vy <= 6)) ? 0 : 1);
                check("R10", "out_r", out_r, vis_prev ? 321 : 0);
                check("R10", "out_b", out_b, vis_prev ? 987 : 0);
            end
            if (k < W_HT && w_pos_valid) w_valid_cnt++;
            if (!w_hsync_n) begin
                w_hs_low++;
                if (w_hs_first < 0) w_hs_first = k;
            end
            check("R1", "wide pos_x", w_pos_x, k % W_HT);
        end
        check("R1", "wide pos_y after one line", w_pos_y, 1);
        check("R2", "wide visible columns per line", w_valid_cnt, 640);
        check("R3", "wide hsync low clocks", w_hs_low, 96);
        check("R3", "wide first hsync low cycle", w_hs_first, 657);

        // Table of layer-selection vectors
        for (int i = 0; i < 8; i++) begin
            logic [CW-1:0] er, eg, eb;
            do @(negedge clk); while (!pos_valid);
            fg_show = VECS[i].show;
            @(negedge clk);
            fg_en = VECS[i].en;
            fg_r = VECS[i].fgv;
            fg_g = VECS[i].fgv ^ 10'h155;
            fg_b = ~VECS[i].fgv;
            bg_r = VECS[i].bgv;
            bg_g = VECS[i].bgv ^ 10'h2AA;
            bg_b = ~VECS[i].bgv;
            fg_show = ~VECS[i].show;   // R6: later value must not matter
            #1;
            er = VECS[i].sel_fg ? fg_r : bg_r;
            eg = VECS[i].sel_fg ? fg_g : bg_g;
            eb = VECS[i].sel_fg ? fg_b : bg_b;
            if (VECS[i].sel_fg) begin
                check("R7 R6", "out_r", out_r, er);
                check("R7 R6", "out_g", out_g, eg);
                check("R7 R6", "out_b", out_b, eb);
            end else if (!VECS[i].show) begin
                check("R9 R6", "out_r", out_r, er);
                check("R9 R6", "out_g", out_g, eg);
                check("R9 R6", "out_b", out_b, eb);
            end else begin
                check("R8 R6", "out_r", out_r, er);
                check("R8 R6", "out_g", out_g, eg);
                check("R8 R6", "out_b", out_b, eb);
            end
        end

        // R6: last visible column, then first blanked column
        fg_show = 1'b1; fg_en = 1'b1;
        fg_r = 10'd77; fg_g = 10'd78; fg_b = 10'd79;
        do @(negedge clk); while (!(pos_valid && pos_x == 4'd7));
        @(negedge clk);
        check("R6", "last column out_g", out_g, 78);
        @(negedge clk);
        check("R10", "first porch column out_g", out_g, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule